// File: doc/BRIEF.md
# Dual-Clock Shared Block Memory with Per-Port Geometry

This block is a dual-port memory over one shared 18-bit by 1024-word array. Each side has its own clock and its own synchronous reset. Each side also has a fixed data width, chosen by parameter from 1, 2, 4, 9 or 18 bits, and its address width follows from that choice: 14, 13, 12, 11 or 10 bits respectively. A width of 0 switches the side off. Any other width is rejected at elaboration.

The array is treated as one long bit string. A side of width W at address A touches bits A*W up to A*W+W-1. Two sides of different widths therefore see the same stored bits, each through its own window.

Every request is captured in an input register on the side's clock. Each side carries a 3-bit select constant, so several instances can hang off one shared bus without an external decoder. Each side also chooses what a write returns, and whether one extra output register follows the memory read.

Top module: `dpram_flex`

## Requirements
- R1: The select, write enable, address and write data of a side are captured in an input register at every rising edge of that side's clock. On a side without the output register, the result of a read captured at edge N is on its read data from edge N+1 on.
- R2: On a side with the output register, the result of a request captured at edge N appears from edge N+2 on. Between edges N+1 and N+2 the output still shows the previous result.
- R3: A request whose 3-bit select differs from the side's select parameter leaves the stored contents and that side's read data unchanged.
- R4: In the plain write mode (encoding 0), a write stores its data and leaves the side's read data at its previous value.
- R5: In the write-forward mode (encoding 1), a write presents the data just written on the read data, with the same latency as a read.
- R6: In the read-first mode (encoding 2), a write presents the value the addressed location held before the write. This mode is accepted only for widths 9 and 18.
- R7: A side of width W at address A accesses bits A*W through A*W+W-1 of the flattened array, whose bit 0 is bit 0 of word 0. Both sides therefore observe one consistent store.
- R8: A 4-bit access whose bit range crosses an 18-bit word boundary reads and writes all four bits correctly.
- R9: While a side's reset is sampled high, the read data of that side is zero from the next edge on. Reset does not alter the stored contents.
- R10: A side configured with width 0 drives zero on its read data and never changes the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of side A |
| rst_a | input | 1 | Synchronous active-high reset of side A |
| sel_a | input | 3 | Select code of side A, compared with CSEL_A |
| we_a | input | 1 | Write enable of side A |
| addr_a | input | AW_A | Address of side A, width set by WIDTH_A |
| wdata_a | input | DW_A | Write data of side A |
| rdata_a | output | DW_A | Read data of side A |
| clk_b | input | 1 | Clock of side B |
| rst_b | input | 1 | Synchronous active-high reset of side B |
| sel_b | input | 3 | Select code of side B, compared with CSEL_B |
| we_b | input | 1 | Write enable of side B |
| addr_b | input | AW_B | Address of side B, width set by WIDTH_B |
| wdata_b | input | DW_B | Write data of side B |
| rdata_b | output | DW_B | Read data of side B |

## Verification
The bench builds two instances.

In the first, side A is 9 bits wide, in read-first mode, without the output register and with select 5. Side B is 4 bits wide, in write-forward mode, with the output register and with select 2. This pairing makes the mixed-width bit mapping visible, including the 4-bit window that spans words 0 and 1. It also covers both latencies and two of the write modes.

In the second, side A is 18 bits wide, in plain mode and registered, and side B has width 0. This covers the plain write mode and the switched-off side.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORD_W      = 18;
  localparam int ARRAY_WORDS = 1024;
  localparam int IDX_W       = $clog2(ARRAY_WORDS);
  localparam int BITPOS_W    = IDX_W + $clog2(WORD_W);

  typedef enum logic [1:0] {
    WM_NORMAL    = 2'd0,
    WM_THROUGH   = 2'd1,
    WM_READFIRST = 2'd2
  } wmode_e;

  function automatic int addr_bits(input int w);
    case (w)
      1:       return 14;
      2:       return 13;
      4:       return 12;
      9:       return 11;
      18:      return 10;
      default: return 1;
    endcase
  endfunction

  function automatic bit width_legal(input int w);
    return (w == 0) || (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18);
  endfunction
endpackage

// File: rtl/dpram_outstage.sv
module dpram_outstage #(
  parameter int DW     = 1,
  parameter bit OUTREG = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)       hold_q <= '0;
    else if (load) hold_q <= din;
  end

  generate
    if (OUTREG) begin : g_pipe
      logic [DW-1:0] pipe_q;
      // second stage is always enabled
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= hold_q;
      end
      assign dout = pipe_q;
    end else begin : g_direct
      assign dout = hold_q;
    end
  endgenerate
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int         W      = 9,
  parameter wmode_e     MODE   = WM_NORMAL,
  parameter bit         OUTREG = 1'b0,
  parameter logic [2:0] CSEL   = 3'd0,
  localparam int        AW     = addr_bits(W),
  localparam int        DW     = W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [IDX_W-1:0]  idx0,
  output logic [IDX_W-1:0]  idx1,
  input  logic [WORD_W-1:0] cur0,
  input  logic [WORD_W-1:0] cur1,
  output logic              wen0,
  output logic              wen1,
  output logic [WORD_W-1:0] nxt0,
  output logic [WORD_W-1:0] nxt1
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WIN_W = 2 * WORD_W;

  logic          act_q, we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  // input capture, every edge
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      act_q   <= (sel == CSEL);
      we_q    <= we;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // locate the lane in the flattened array
  logic [BITPOS_W-1:0] bitpos;
  logic [IDX_W-1:0]    word0;
  logic [4:0]          off;
  logic                spill;

  assign bitpos = BITPOS_W'(addr_q) * BITPOS_W'(W);
  assign word0  = IDX_W'(bitpos / WORD_W);
  assign off    = 5'(bitpos % WORD_W);
  assign spill  = (int'(off) + W) > WORD_W;
  assign idx0   = word0;
  assign idx1   = (word0 == IDX_W'(ARRAY_WORDS - 1)) ? word0 : word0 + 1'b1;

  logic [WIN_W-1:0] win, shifted, lane_mask, ins, merged;
  logic [DW-1:0]    old_val;

  assign win       = {cur1, cur0};
  assign shifted   = win >> off;
  assign old_val   = shifted[DW-1:0];
  assign lane_mask = {{(WIN_W - DW){1'b0}}, {DW{1'b1}}} << off;
  assign ins       = {{(WIN_W - DW){1'b0}}, wdata_q} << off;
  assign merged    = (win & ~lane_mask) | ins;

  assign nxt0 = merged[WORD_W-1:0];
  assign nxt1 = merged[WIN_W-1:WORD_W];
  assign wen0 = act_q & we_q;
  assign wen1 = act_q & we_q & spill;

  // write-output behaviour
  logic          out_load;
  logic [DW-1:0] out_val;

  assign out_load = act_q & (~we_q | (MODE != WM_NORMAL));
  assign out_val  = (we_q && (MODE == WM_THROUGH)) ? wdata_q : old_val;

  dpram_outstage #(.DW(DW), .OUTREG(OUTREG)) out_i (
    .clk  (clk),
    .rst  (rst),
    .load (out_load),
    .din  (out_val),
    .dout (rdata)
  );
endmodule

// File: rtl/dpram_flex.sv
module dpram_flex
  import dpram_pkg::*;
#(
  parameter int         WIDTH_A  = 9,
  parameter wmode_e     MODE_A   = WM_NORMAL,
  parameter bit         OUTREG_A = 1'b0,
  parameter logic [2:0] CSEL_A   = 3'd0,
  parameter int         WIDTH_B  = 18,
  parameter wmode_e     MODE_B   = WM_THROUGH,
  parameter bit         OUTREG_B = 1'b1,
  parameter logic [2:0] CSEL_B   = 3'd1,
  localparam int        AW_A     = addr_bits(WIDTH_A),
  localparam int        DW_A     = (WIDTH_A == 0) ? 1 : WIDTH_A,
  localparam int        AW_B     = addr_bits(WIDTH_B),
  localparam int        DW_B     = (WIDTH_B == 0) ? 1 : WIDTH_B
) (
  input  logic            clk_a,
  input  logic            rst_a,
  input  logic [2:0]      sel_a,
  input  logic            we_a,
  input  logic [AW_A-1:0] addr_a,
  input  logic [DW_A-1:0] wdata_a,
  output logic [DW_A-1:0] rdata_a,
  input  logic            clk_b,
  input  logic            rst_b,
  input  logic [2:0]      sel_b,
  input  logic            we_b,
  input  logic [AW_B-1:0] addr_b,
  input  logic [DW_B-1:0] wdata_b,
  output logic [DW_B-1:0] rdata_b
);
  timeunit 1ns;
  timeprecision 1ps;

  // configuration checks
  generate
    if (!width_legal(WIDTH_A)) begin : g_bad_width_a
      $error("side A width must be 0, 1, 2, 4, 9 or 18");
    end
    if (!width_legal(WIDTH_B)) begin : g_bad_width_b
      $error("side B width must be 0, 1, 2, 4, 9 or 18");
    end
    if (MODE_A == WM_READFIRST && WIDTH_A != 9 && WIDTH_A != 18) begin : g_bad_mode_a
      $error("side A read-first mode needs width 9 or 18");
    end
    if (MODE_B == WM_READFIRST && WIDTH_B != 9 && WIDTH_B != 18) begin : g_bad_mode_b
      $error("side B read-first mode needs width 9 or 18");
    end
  endgenerate

  // Stored word = bank A xor bank B; each bank written by one clock only.
  logic [IDX_W-1:0]  a_idx0, a_idx1, b_idx0, b_idx1;
  logic              a_wen0, a_wen1, b_wen0, b_wen1;
  logic [WORD_W-1:0] a_nxt0, a_nxt1, b_nxt0, b_nxt1;
  logic [WORD_W-1:0] ra_at_a0, ra_at_a1, ra_at_b0, ra_at_b1;
  logic [WORD_W-1:0] rb_at_a0, rb_at_a1, rb_at_b0, rb_at_b1;
  logic [WORD_W-1:0] a_cur0, a_cur1, b_cur0, b_cur1;

  assign a_cur0 = ra_at_a0 ^ rb_at_a0;
  assign a_cur1 = ra_at_a1 ^ rb_at_a1;
  assign b_cur0 = ra_at_b0 ^ rb_at_b0;
  assign b_cur1 = ra_at_b1 ^ rb_at_b1;

  generate
    if (WIDTH_A > 0) begin : g_side_a
      logic [WORD_W-1:0] bank_q [ARRAY_WORDS];

      dpram_port #(.W(WIDTH_A), .MODE(MODE_A), .OUTREG(OUTREG_A), .CSEL(CSEL_A)) port_i (
        .clk(clk_a), .rst(rst_a), .sel(sel_a), .we(we_a), .addr(addr_a),
        .wdata(wdata_a), .rdata(rdata_a), .idx0(a_idx0), .idx1(a_idx1),
        .cur0(a_cur0), .cur1(a_cur1), .wen0(a_wen0), .wen1(a_wen1),
        .nxt0(a_nxt0), .nxt1(a_nxt1)
      );

      always_ff @(posedge clk_a) begin
        if (a_wen0) bank_q[a_idx0] <= a_nxt0 ^ rb_at_a0;
        if (a_wen1) bank_q[a_idx1] <= a_nxt1 ^ rb_at_a1;
      end

      assign ra_at_a0 = bank_q[a_idx0];
      assign ra_at_a1 = bank_q[a_idx1];
      assign ra_at_b0 = bank_q[b_idx0];
      assign ra_at_b1 = bank_q[b_idx1];
    end else begin : g_off_a
      assign rdata_a  = '0;
      assign a_idx0   = '0;
      assign a_idx1   = '0;
      assign a_wen0   = 1'b0;
      assign a_wen1   = 1'b0;
      assign a_nxt0   = '0;
      assign a_nxt1   = '0;
      assign ra_at_a0 = '0;
      assign ra_at_a1 = '0;
      assign ra_at_b0 = '0;
      assign ra_at_b1 = '0;
    end

    if (WIDTH_B > 0) begin : g_side_b
      logic [WORD_W-1:0] bank_q [ARRAY_WORDS];

      dpram_port #(.W(WIDTH_B), .MODE(MODE_B), .OUTREG(OUTREG_B), .CSEL(CSEL_B)) port_i (
        .clk(clk_b), .rst(rst_b), .sel(sel_b), .we(we_b), .addr(addr_b),
        .wdata(wdata_b), .rdata(rdata_b), .idx0(b_idx0), .idx1(b_idx1),
        .cur0(b_cur0), .cur1(b_cur1), .wen0(b_wen0), .wen1(b_wen1),
        .nxt0(b_nxt0), .nxt1(b_nxt1)
      );

      always_ff @(posedge clk_b) begin
        if (b_wen0) bank_q[b_idx0] <= b_nxt0 ^ ra_at_b0;
        if (b_wen1) bank_q[b_idx1] <= b_nxt1 ^ ra_at_b1;
      end

      assign rb_at_b0 = bank_q[b_idx0];
      assign rb_at_b1 = bank_q[b_idx1];
      assign rb_at_a0 = bank_q[a_idx0];
      assign rb_at_a1 = bank_q[a_idx1];
    end else begin : g_off_b
      assign rdata_b  = '0;
      assign b_idx0   = '0;
      assign b_idx1   = '0;
      assign b_wen0   = 1'b0;
      assign b_wen1   = 1'b0;
      assign b_nxt0   = '0;
      assign b_nxt1   = '0;
      assign rb_at_b0 = '0;
      assign rb_at_b1 = '0;
      assign rb_at_a0 = '0;
      assign rb_at_a1 = '0;
    end
  endgenerate
endmodule

// File: rtl/dpram_flex_chk.sv
module dpram_flex_chk
  import dpram_pkg::*;
#(
  parameter int         WIDTH_A  = 9,
  parameter wmode_e     MODE_A   = WM_NORMAL,
  parameter bit         OUTREG_A = 1'b0,
  parameter logic [2:0] CSEL_A   = 3'd0,
  parameter int         WIDTH_B  = 18,
  parameter wmode_e     MODE_B   = WM_THROUGH,
  parameter bit         OUTREG_B = 1'b1,
  parameter logic [2:0] CSEL_B   = 3'd1,
  localparam int        DW_A     = (WIDTH_A == 0) ? 1 : WIDTH_A,
  localparam int        DW_B     = (WIDTH_B == 0) ? 1 : WIDTH_B
) (
  input logic            clk_a,
  input logic            rst_a,
  input logic [2:0]      sel_a,
  input logic            we_a,
  input logic [DW_A-1:0] rdata_a,
  input logic            clk_b,
  input logic            rst_b,
  input logic [2:0]      sel_b,
  input logic            we_b,
  input logic [DW_B-1:0] wdata_b,
  input logic [DW_B-1:0] rdata_b
);
  timeunit 1ns;
  timeprecision 1ps;

  generate
    if (OUTREG_A) begin : g_a_slow
      // R3
      a_ignore_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (sel_a != CSEL_A) |=> ##2 $stable(rdata_a));
      if (MODE_A == WM_NORMAL && WIDTH_A > 0) begin : g_plain
        // R4
        a_plain_hold_chk: assert property (@(posedge clk_a) disable iff (rst_a)
          (sel_a == CSEL_A && we_a) |=> ##2 $stable(rdata_a));
      end
    end else begin : g_a_fast
      // R3
      a_ignore_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (sel_a != CSEL_A) |=> ##1 $stable(rdata_a));
      if (MODE_A == WM_NORMAL && WIDTH_A > 0) begin : g_plain
        // R4
        a_plain_hold_chk: assert property (@(posedge clk_a) disable iff (rst_a)
          (sel_a == CSEL_A && we_a) |=> ##1 $stable(rdata_a));
      end
    end

    if (MODE_B == WM_THROUGH && WIDTH_B > 0) begin : g_b_fwd
      if (OUTREG_B) begin : g_slow
        // R5
        b_forward_chk: assert property (@(posedge clk_b) disable iff (rst_b)
          (sel_b == CSEL_B && we_b) |-> ##3 (rdata_b == $past(wdata_b, 3)));
      end else begin : g_fast
        // R5
        b_forward_chk: assert property (@(posedge clk_b) disable iff (rst_b)
          (sel_b == CSEL_B && we_b) |-> ##2 (rdata_b == $past(wdata_b, 2)));
      end
    end
  endgenerate

  logic a_rst_seen_q, b_rst_seen_q;
  always_ff @(posedge clk_a) a_rst_seen_q <= rst_a;
  always_ff @(posedge clk_b) b_rst_seen_q <= rst_b;

  always @(negedge clk_a) begin
    if (a_rst_seen_q) begin
      // R9
      a_rst_clear_chk: assert (rdata_a == '0);
    end
  end

  always @(negedge clk_b) begin
    if (b_rst_seen_q) begin
      // R9
      b_rst_clear_chk: assert (rdata_b == '0);
    end
  end
endmodule

bind dpram_flex dpram_flex_chk #(
  .WIDTH_A(WIDTH_A), .MODE_A(MODE_A), .OUTREG_A(OUTREG_A), .CSEL_A(CSEL_A),
  .WIDTH_B(WIDTH_B), .MODE_B(MODE_B), .OUTREG_B(OUTREG_B), .CSEL_B(CSEL_B)
) chk_i (
  .clk_a(clk_a), .rst_a(rst_a), .sel_a(sel_a), .we_a(we_a), .rdata_a(rdata_a),
  .clk_b(clk_b), .rst_b(rst_b), .sel_b(sel_b), .we_b(we_b), .wdata_b(wdata_b),
  .rdata_b(rdata_b)
);

// File: tb/dpram_flex_tb_top.sv
module dpram_flex_tb_top;
  import dpram_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [2:0] SEL_A = 3'd5;
  localparam logic [2:0] SEL_B = 3'd2;
  localparam logic [2:0] SEL_N = 3'd7;
  localparam logic [2:0] IDLE  = 3'd0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [2:0]  sel_a, sel_b, n_sel_a, n_sel_b;
  logic        we_a, we_b, n_we_a, n_we_b;
  logic [10:0] addr_a;
  logic [11:0] addr_b;
  logic [9:0]  n_addr_a;
  logic [0:0]  n_addr_b;
  logic [8:0]  wdata_a, rdata_a;
  logic [3:0]  wdata_b, rdata_b;
  logic [17:0] n_wdata_a, n_rdata_a;
  logic [0:0]  n_wdata_b, n_rdata_b;

  dpram_flex #(
    .WIDTH_A(9), .MODE_A(WM_READFIRST), .OUTREG_A(1'b0), .CSEL_A(SEL_A),
    .WIDTH_B(4), .MODE_B(WM_THROUGH),   .OUTREG_B(1'b1), .CSEL_B(SEL_B)
  ) dut_i (
    .clk_a(clk), .rst_a(rst), .sel_a(sel_a), .we_a(we_a), .addr_a(addr_a),
    .wdata_a(wdata_a), .rdata_a(rdata_a),
    .clk_b(clk), .rst_b(rst), .sel_b(sel_b), .we_b(we_b), .addr_b(addr_b),
    .wdata_b(wdata_b), .rdata_b(rdata_b)
  );

  dpram_flex #(
    .WIDTH_A(18), .MODE_A(WM_NORMAL), .OUTREG_A(1'b1), .CSEL_A(SEL_N),
    .WIDTH_B(0),  .MODE_B(WM_NORMAL), .OUTREG_B(1'b0), .CSEL_B(3'd3)
  ) dut_n_i (
    .clk_a(clk), .rst_a(rst), .sel_a(n_sel_a), .we_a(n_we_a), .addr_a(n_addr_a),
    .wdata_a(n_wdata_a), .rdata_a(n_rdata_a),
    .clk_b(clk), .rst_b(rst), .sel_b(n_sel_b), .we_b(n_we_b), .addr_b(n_addr_b),
    .wdata_b(n_wdata_b), .rdata_b(n_rdata_b)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [18431:0] ref_bits = '0;

  function automatic logic [17:0] ref_get(input int pos, input int w);
    logic [18431:0] sh;
    sh = ref_bits >> pos;
    return sh[17:0] & ((18'd1 << w) - 18'd1);
  endfunction

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic a_access(input logic [2:0] s, input logic w, input int adr,
                          input logic [8:0] d, output logic [8:0] got);
    @(negedge clk);
    sel_a = s; we_a = w; addr_a = 11'(adr); wdata_a = d;
    @(negedge clk);
    sel_a = IDLE; we_a = 1'b0;
    @(negedge clk);
    got = rdata_a;
    if (s == SEL_A && w) ref_bits[adr*9 +: 9] = d;
  endtask

  task automatic b_access(input logic [2:0] s, input logic w, input int adr,
                          input logic [3:0] d, output logic [3:0] g1, output logic [3:0] g2);
    @(negedge clk);
    sel_b = s; we_b = w; addr_b = 12'(adr); wdata_b = d;
    @(negedge clk);
    sel_b = IDLE; we_b = 1'b0;
    @(negedge clk);
    g1 = rdata_b;
    @(negedge clk);
    g2 = rdata_b;
    if (s == SEL_B && w) ref_bits[adr*4 +: 4] = d;
  endtask

  task automatic n_access(input logic w, input int adr, input logic [17:0] d,
                          output logic [17:0] g1, output logic [17:0] g2);
    @(negedge clk);
    n_sel_a = SEL_N; n_we_a = w; n_addr_a = 10'(adr); n_wdata_a = d;
    @(negedge clk);
    n_sel_a = IDLE; n_we_a = 1'b0;
    @(negedge clk);
    g1 = n_rdata_a;
    @(negedge clk);
    g2 = n_rdata_a;
  endtask

  task automatic t_reset_state();
    check("R9 side A zero after reset", 18'(rdata_a), 18'h0);
    check("R9 side B zero after reset", 18'(rdata_b), 18'h0);
    check("R9 second instance zero after reset", n_rdata_a, 18'h0);
  endtask

  task automatic t_read_first();
    logic [8:0] g;
    a_access(SEL_A, 1'b1, 3, 9'h155, g);
    a_access(SEL_A, 1'b1, 3, 9'h0AA, g);
    check("R6 write returns previous contents", 18'(g), 18'h155);
    a_access(SEL_A, 1'b0, 3, 9'h000, g);
    check("R1 read one cycle after capture", 18'(g), 18'h0AA);
  endtask

  task automatic t_cross_width();
    logic [8:0] g;
    logic [3:0] g1, g2;
    a_access(SEL_A, 1'b1, 0, 9'h1A5, g);
    a_access(SEL_A, 1'b1, 1, 9'h0C3, g);
    a_access(SEL_A, 1'b1, 2, 9'h1FF, g);
    for (int k = 0; k < 6; k++) begin
      b_access(SEL_B, 1'b0, k, 4'h0, g1, g2);
      check($sformatf("R7 narrow view of nibble %0d", k), 18'(g2), ref_get(4*k, 4));
    end
  endtask

  task automatic t_forward();
    logic [3:0] prev, g1, g2;
    prev = rdata_b;
    b_access(SEL_B, 1'b1, 7, 4'hC, g1, g2);
    check("R2 previous result one cycle after capture", 18'(g1), 18'(prev));
    check("R5 write forwards new data", 18'(g2), 18'hC);
    b_access(SEL_B, 1'b0, 7, 4'h0, g1, g2);
    check("R2 registered read after two cycles", 18'(g2), 18'hC);
  endtask

  task automatic t_straddle();
    logic [8:0] g;
    logic [3:0] g1, g2;
    b_access(SEL_B, 1'b1, 4, 4'h9, g1, g2);
    a_access(SEL_A, 1'b0, 1, 9'h000, g);
    check("R8 low word part of spanning write", 18'(g), ref_get(9, 9));
    a_access(SEL_A, 1'b0, 2, 9'h000, g);
    check("R8 high word part of spanning write", 18'(g), ref_get(18, 9));
    b_access(SEL_B, 1'b0, 4, 4'h0, g1, g2);
    check("R8 spanning nibble read back", 18'(g2), 18'h9);
  endtask

  task automatic t_ignore();
    logic [8:0] prev_a, g;
    logic [3:0] prev_b, g1, g2;
    prev_a = rdata_a;
    a_access(3'd4, 1'b1, 0, 9'h000, g);
    check("R3 mismatched select holds side A output", 18'(g), 18'(prev_a));
    a_access(SEL_A, 1'b0, 0, 9'h000, g);
    check("R3 mismatched write left word intact", 18'(g), ref_get(0, 9));
    prev_b = rdata_b;
    b_access(3'd6, 1'b1, 0, 4'h0, g1, g2);
    check("R3 mismatched select holds side B output", 18'(g2), 18'(prev_b));
    b_access(SEL_B, 1'b0, 0, 4'h0, g1, g2);
    check("R3 mismatched write left nibble intact", 18'(g2), ref_get(0, 4));
  endtask

  task automatic t_reset_keeps();
    logic [8:0] g;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 side A cleared by reset", 18'(rdata_a), 18'h0);
    check("R9 side B cleared by reset", 18'(rdata_b), 18'h0);
    rst = 1'b0;
    a_access(SEL_A, 1'b0, 2, 9'h000, g);
    check("R9 contents survive reset", 18'(g), ref_get(18, 9));
  endtask

  task automatic t_plain();
    logic [17:0] prev, g1, g2;
    prev = n_rdata_a;
    n_access(1'b1, 10, 18'h2ABCD, g1, g2);
    check("R4 plain write holds output (1 cycle)", g1, prev);
    check("R4 plain write holds output (2 cycles)", g2, prev);
    n_access(1'b0, 10, 18'h0, g1, g2);
    check("R2 registered output not yet updated", g1, prev);
    check("R4 plain write stored data", g2, 18'h2ABCD);
  endtask

  task automatic t_disabled();
    logic [17:0] g1, g2;
    @(negedge clk);
    n_sel_b = 3'd3; n_we_b = 1'b1; n_addr_b = 1'b0; n_wdata_b = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 disabled side reads zero", 18'(n_rdata_b), 18'h0);
    end
    n_sel_b = IDLE; n_we_b = 1'b0;
    n_access(1'b0, 10, 18'h0, g1, g2);
    check("R10 disabled side left array intact", g2, 18'h2ABCD);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    sel_a = IDLE; we_a = 1'b0; addr_a = '0; wdata_a = '0;
    sel_b = IDLE; we_b = 1'b0; addr_b = '0; wdata_b = '0;
    n_sel_a = IDLE; n_we_a = 1'b0; n_addr_a = '0; n_wdata_a = '0;
    n_sel_b = IDLE; n_we_b = 1'b0; n_addr_b = '0; n_wdata_b = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_read_first();
    t_cross_width();
    t_forward();
    t_straddle();
    t_ignore();
    t_reset_keeps();
    t_plain();
    t_disabled();
    done = 1'b1;
    finish_run();
  end
endmodule